// File: doc/BRIEF.md
# Timer Slave-Mode Synchronization Controller

This block lets an external event steer a prescaled up-counter. One trigger path is picked from two timer inputs by an encoded select field. The slave-mode field then decides what that trigger does. It can clear the counter and its prescaler, it can gate counting with the trigger's level, or a rising edge can start the counter. When the mode is off, only the software run bit matters.

The counter, the prescaler and the preloaded auto-reload and compare registers are part of the block, so the effect of each mode can be seen at the ports. An update event copies the preloaded auto-reload and compare values into the active registers. An update event comes from a counter wrap. In clear mode it also comes from a trigger, but only while the update-request-source bit is low.

Top module: `tmr_slave_sync`

## Requirements
- R1: While `rst` is high and after it is released, `cnt_o`, `run_o`, `clr_o` and `upd_o` are 0, `arr_act_o` is all ones and `cmp_act_o` is 0.
- R2: With `slave_mode_i` = 3'b000 (off), trigger edges have no effect. Counting follows `sw_run_i` alone. `run_o` goes high on the first clock edge after `sw_run_i` is sampled high, and the counter advances from the next edge on.
- R3: With `slave_mode_i` = 3'b100 (clear mode), a rising edge of the selected input is detected on the first clock edge that samples it high. On the next edge the counter and the prescaler go to 0 and `clr_o` pulses for one cycle. An input that stays high causes no further clear.
- R4: In clear mode with `urs_i` low, `upd_o` pulses in the same cycle as `clr_o`, and `arr_act_o`/`cmp_act_o` take the values of `arr_pre_i`/`cmp_pre_i`.
- R5: In clear mode with `urs_i` high, the clear happens but `upd_o` stays low and `arr_act_o`/`cmp_act_o` keep their values.
- R6: With `slave_mode_i` = 3'b101 (gated mode) and `sw_run_i` high, `run_o` follows the level of the selected input with a lag of two clock edges. While `run_o` is low the counter holds its value and is never cleared.
- R7: With `slave_mode_i` = 3'b110 (start mode), a rising edge of the selected input sets `run_o` two edges after the input rises, even if `sw_run_i` is low. `run_o` stays set after the input falls and is dropped once the mode leaves 3'b110.
- R8: `trig_sel_i` = 3'b101 selects `tin_a_i` and 3'b110 selects `tin_b_i`. Any other value selects no trigger, and the input that is not selected has no effect.
- R9: While running, the prescaler lets the counter advance once every `psc_i`+1 clock cycles.
- R10: When the counter advances while it equals `arr_act_o`, it wraps to 0, `upd_o` pulses for one cycle, and the preloaded values become active. The active values do not change when there is no update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_run_i | input | 1 | Software counter-run bit |
| slave_mode_i | input | 3 | 000 off, 100 clear, 101 gated, 110 start |
| trig_sel_i | input | 3 | 101 input A, 110 input B, other none |
| urs_i | input | 1 | High: a clear-mode trigger raises no update |
| tin_a_i | input | 1 | Timer input A (already synchronous) |
| tin_b_i | input | 1 | Timer input B (already synchronous) |
| psc_i | input | PSC_W | Prescaler divide value minus one |
| arr_pre_i | input | CNT_W | Preloaded auto-reload value |
| cmp_pre_i | input | CNT_W | Preloaded compare value |
| cnt_o | output | CNT_W | Counter value |
| run_o | output | 1 | Effective counter enable |
| clr_o | output | 1 | One-cycle pulse: counter and prescaler were cleared |
| upd_o | output | 1 | One-cycle update-event pulse |
| arr_act_o | output | CNT_W | Active auto-reload value |
| cmp_act_o | output | CNT_W | Active compare value |

## Verification
Clear mode is driven with single edges, with a held-high input, and with edges on the input that is not selected. This shows an edge apart from a level and shows that the select field routes only the chosen input. Each update-request-source setting is paired with a change to the preloaded values, so an update that is missing or unwanted shows up directly in the active registers. Gated mode gets gate pulses on and off, which shows a hold apart from a clear. Start mode gets a short pulse with the software bit low, which shows a latched start apart from a gate. A sweep over four prescaler values, with the auto-reload value changed after the first load, counts the ticks and finds each wrap, update and reload cycle arithmetically.

// File: rtl/tss_pkg.sv
package tss_pkg;
  localparam logic [2:0] MODE_OFF   = 3'b000;
  localparam logic [2:0] MODE_CLEAR = 3'b100;
  localparam logic [2:0] MODE_GATE  = 3'b101;
  localparam logic [2:0] MODE_START = 3'b110;

  localparam logic [2:0] SEL_IN_A   = 3'b101;
  localparam logic [2:0] SEL_IN_B   = 3'b110;
endpackage

// File: rtl/tss_trig_path.sv
module tss_trig_path
  import tss_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] sel_i,
  input  logic       in_a_i,
  input  logic       in_b_i,
  output logic       lvl_o,
  output logic       evt_o
);
  logic a_q, b_q;
  logic sel_now, sel_prev;

  always_comb begin
    case (sel_i)
      SEL_IN_A: begin sel_now = in_a_i; sel_prev = a_q; end
      SEL_IN_B: begin sel_now = in_b_i; sel_prev = b_q; end
      default:  begin sel_now = 1'b0;   sel_prev = 1'b0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q   <= 1'b0;
      b_q   <= 1'b0;
      lvl_o <= 1'b0;
      evt_o <= 1'b0;
    end else begin
      a_q   <= in_a_i;
      b_q   <= in_b_i;
      lvl_o <= sel_now;
      evt_o <= sel_now & ~sel_prev;
    end
  end
endmodule

// File: rtl/tss_mode_ctl.sv
module tss_mode_ctl
  import tss_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] mode_i,
  input  logic       sw_run_i,
  input  logic       urs_i,
  input  logic       trg_lvl_i,
  input  logic       trg_evt_i,
  output logic       run_o,
  output logic       clr_req_o,
  output logic       clr_upd_o
);
  logic started_q;
  logic run_next;

  always_comb begin
    case (mode_i)
      MODE_GATE:  run_next = sw_run_i & trg_lvl_i;
      MODE_START: run_next = sw_run_i | started_q | trg_evt_i;
      default:    run_next = sw_run_i;
    endcase
  end

  assign clr_req_o = (mode_i == MODE_CLEAR) & trg_evt_i;
  assign clr_upd_o = clr_req_o & ~urs_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      started_q <= 1'b0;
      run_o     <= 1'b0;
    end else begin
      started_q <= (mode_i == MODE_START) ? (started_q | trg_evt_i) : 1'b0;
      run_o     <= run_next;
    end
  end
endmodule

// File: rtl/tss_counter.sv
module tss_counter #(
  parameter int CNT_W = 8,
  parameter int PSC_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic             clr_upd_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic [CNT_W-1:0] arr_pre_i,
  input  logic [CNT_W-1:0] cmp_pre_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] arr_act_o,
  output logic [CNT_W-1:0] cmp_act_o,
  output logic             upd_o,
  output logic             clr_o
);
  localparam logic [CNT_W-1:0] ARR_RST = {CNT_W{1'b1}};

  logic [PSC_W-1:0] psc_q;
  logic             tick;
  logic             wrap;

  assign tick = run_i && (psc_q >= psc_i);
  assign wrap = tick && (cnt_o >= arr_act_o);

  always_ff @(posedge clk) begin
    if (rst) begin
      psc_q     <= '0;
      cnt_o     <= '0;
      arr_act_o <= ARR_RST;
      cmp_act_o <= '0;
      upd_o     <= 1'b0;
      clr_o     <= 1'b0;
    end else begin
      clr_o <= clr_i;
      upd_o <= 1'b0;
      if (clr_i) begin
        psc_q <= '0;
        cnt_o <= '0;
        if (clr_upd_i) begin
          upd_o     <= 1'b1;
          arr_act_o <= arr_pre_i;
          cmp_act_o <= cmp_pre_i;
        end
      end else if (run_i) begin
        if (tick) begin
          psc_q <= '0;
          if (wrap) begin
            cnt_o     <= '0;
            upd_o     <= 1'b1;
            arr_act_o <= arr_pre_i;
            cmp_act_o <= cmp_pre_i;
          end else begin
            cnt_o <= cnt_o + 1'b1;
          end
        end else begin
          psc_q <= psc_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tmr_slave_sync.sv
module tmr_slave_sync #(
  parameter int CNT_W = 8,
  parameter int PSC_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sw_run_i,
  input  logic [2:0]       slave_mode_i,
  input  logic [2:0]       trig_sel_i,
  input  logic             urs_i,
  input  logic             tin_a_i,
  input  logic             tin_b_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic [CNT_W-1:0] arr_pre_i,
  input  logic [CNT_W-1:0] cmp_pre_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o,
  output logic             clr_o,
  output logic             upd_o,
  output logic [CNT_W-1:0] arr_act_o,
  output logic [CNT_W-1:0] cmp_act_o
);
  logic trg_lvl, trg_evt;
  logic clr_req, clr_upd;

  tss_trig_path u_trig (
    .clk    (clk),
    .rst    (rst),
    .sel_i  (trig_sel_i),
    .in_a_i (tin_a_i),
    .in_b_i (tin_b_i),
    .lvl_o  (trg_lvl),
    .evt_o  (trg_evt)
  );

  tss_mode_ctl u_mode (
    .clk       (clk),
    .rst       (rst),
    .mode_i    (slave_mode_i),
    .sw_run_i  (sw_run_i),
    .urs_i     (urs_i),
    .trg_lvl_i (trg_lvl),
    .trg_evt_i (trg_evt),
    .run_o     (run_o),
    .clr_req_o (clr_req),
    .clr_upd_o (clr_upd)
  );

  tss_counter #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .run_i     (run_o),
    .clr_i     (clr_req),
    .clr_upd_i (clr_upd),
    .psc_i     (psc_i),
    .arr_pre_i (arr_pre_i),
    .cmp_pre_i (cmp_pre_i),
    .cnt_o     (cnt_o),
    .arr_act_o (arr_act_o),
    .cmp_act_o (cmp_act_o),
    .upd_o     (upd_o),
    .clr_o     (clr_o)
  );
endmodule

// File: rtl/tmr_slave_sync_chk.sv
module tmr_slave_sync_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             urs_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic             run_o,
  input logic             clr_o,
  input logic             upd_o,
  input logic [CNT_W-1:0] arr_act_o,
  input logic [CNT_W-1:0] cmp_act_o
);
  assert_clear_zero_R3: assert property (@(posedge clk) disable iff (rst)
    clr_o |-> (cnt_o == '0));

  assert_no_upd_when_urs_R5: assert property (@(posedge clk) disable iff (rst)
    (clr_o && $past(urs_i)) |-> !upd_o);

  assert_active_stable_R10: assert property (@(posedge clk) disable iff (rst)
    !upd_o |-> ($stable(arr_act_o) && $stable(cmp_act_o)));

  assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !run_o |=> ((cnt_o == $past(cnt_o)) || clr_o));

  assert_step_or_wrap_R9: assert property (@(posedge clk) disable iff (rst)
    (cnt_o != $past(cnt_o)) |-> ((cnt_o == $past(cnt_o) + 1'b1) || (cnt_o == '0)));

  assert_upd_at_zero_R4: assert property (@(posedge clk) disable iff (rst)
    upd_o |-> (cnt_o == '0));
endmodule

bind tmr_slave_sync tmr_slave_sync_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .urs_i     (urs_i),
  .cnt_o     (cnt_o),
  .run_o     (run_o),
  .clr_o     (clr_o),
  .upd_o     (upd_o),
  .arr_act_o (arr_act_o),
  .cmp_act_o (cmp_act_o)
);

// File: tb/tmr_slave_sync_tb.sv
module tmr_slave_sync_tb;
  localparam int CNT_W = 8;
  localparam int PSC_W = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             sw_run = 1'b0;
  logic [2:0]       mode = 3'b000;
  logic [2:0]       tsel = 3'b000;
  logic             urs = 1'b0;
  logic             tin_a = 1'b0;
  logic             tin_b = 1'b0;
  logic [PSC_W-1:0] psc = '0;
  logic [CNT_W-1:0] arr_pre = '0;
  logic [CNT_W-1:0] cmp_pre = '0;
  logic [CNT_W-1:0] cnt, arr_act, cmp_act;
  logic             run, clr, upd;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tmr_slave_sync #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_dut (
    .clk(clk), .rst(rst), .sw_run_i(sw_run), .slave_mode_i(mode),
    .trig_sel_i(tsel), .urs_i(urs), .tin_a_i(tin_a), .tin_b_i(tin_b),
    .psc_i(psc), .arr_pre_i(arr_pre), .cmp_pre_i(cmp_pre),
    .cnt_o(cnt), .run_o(run), .clr_o(clr), .upd_o(upd),
    .arr_act_o(arr_act), .cmp_act_o(cmp_act)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; sw_run = 1'b0; mode = 3'b000; tsel = 3'b000; urs = 1'b0;
    tin_a = 1'b0; tin_b = 1'b0; psc = '0; arr_pre = '0; cmp_pre = '0;
    tick(3);
    rst = 1'b0;
    tick(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    do_reset();
    chk("R1 cnt", int'(cnt), 0);
    chk("R1 run", int'(run), 0);
    chk("R1 clr", int'(clr), 0);
    chk("R1 upd", int'(upd), 0);
    chk("R1 arr_act", int'(arr_act), 255);
    chk("R1 cmp_act", int'(cmp_act), 0);

    // R2: mode off, triggers ignored
    tsel = 3'b101; tin_a = 1'b1;
    tick(4);
    chk("R2 no count without sw_run", int'(cnt), 0);
    chk("R2 no clear from trigger", int'(clr), 0);
    sw_run = 1'b1;
    tick(1);
    chk("R2 run after one edge", int'(run), 1);
    tick(4);
    chk("R2 counting", int'(cnt), 4);
    tin_a = 1'b0; tick(1); tin_a = 1'b1; tick(3);
    chk("R2 edge ignored", int'(cnt), 8);

    // R3 R4 R8: clear mode
    do_reset();
    mode = 3'b100; tsel = 3'b101; sw_run = 1'b1; arr_pre = 8'd200; cmp_pre = 8'd77;
    tick(6);
    chk("R3 pre-count", int'(cnt), 5);
    tin_a = 1'b1;
    tick(1);
    chk("R3 detect edge, not yet cleared", int'(cnt), 6);
    chk("R3 clr low at detect", int'(clr), 0);
    tick(1);
    chk("R3 cleared", int'(cnt), 0);
    chk("R3 clr pulse", int'(clr), 1);
    chk("R4 upd with clear", int'(upd), 1);
    chk("R4 arr loaded", int'(arr_act), 200);
    chk("R4 cmp loaded", int'(cmp_act), 77);
    tick(1);
    chk("R3 counting again", int'(cnt), 1);
    chk("R3 clr one cycle", int'(clr), 0);
    chk("R4 upd one cycle", int'(upd), 0);
    tick(4);
    chk("R3 held high no reclear", int'(cnt), 5);
    tin_b = 1'b1;
    tick(3);
    chk("R8 unselected input B ignored", int'(cnt), 8);
    tsel = 3'b110; tin_b = 1'b0;
    tick(1);
    tin_b = 1'b1;
    tick(2);
    chk("R8 input B selected clears", int'(cnt), 0);
    chk("R8 input B clr", int'(clr), 1);
    tsel = 3'b111; tin_a = 1'b0; tin_b = 1'b0;
    tick(1);
    tin_a = 1'b1; tin_b = 1'b1;
    tick(3);
    chk("R8 no trigger selected", int'(cnt), 4);

    // R5: update suppressed
    tsel = 3'b101; urs = 1'b1; arr_pre = 8'd50; cmp_pre = 8'd9; tin_a = 1'b0;
    tick(1);
    tin_a = 1'b1;
    tick(2);
    chk("R5 cleared", int'(cnt), 0);
    chk("R5 clr", int'(clr), 1);
    chk("R5 no upd", int'(upd), 0);
    chk("R5 arr kept", int'(arr_act), 200);
    chk("R5 cmp kept", int'(cmp_act), 77);
    urs = 1'b0; tin_a = 1'b0;
    tick(1);
    tin_a = 1'b1;
    tick(2);
    chk("R4 upd after urs low", int'(upd), 1);
    chk("R4 arr reloaded", int'(arr_act), 50);
    chk("R4 cmp reloaded", int'(cmp_act), 9);

    // R6: gated mode
    do_reset();
    mode = 3'b101; tsel = 3'b110; sw_run = 1'b1;
    tick(5);
    chk("R6 gate low no count", int'(cnt), 0);
    chk("R6 gate low run", int'(run), 0);
    tin_b = 1'b1;
    tick(2);
    chk("R6 run two edges later", int'(run), 1);
    tick(3);
    chk("R6 counting while high", int'(cnt), 3);
    tin_b = 1'b0;
    tick(5);
    chk("R6 two more then hold", int'(cnt), 5);
    chk("R6 run low", int'(run), 0);
    tick(4);
    chk("R6 holds without reset", int'(cnt), 5);
    tin_b = 1'b1;
    tick(5);
    chk("R6 resumes from held value", int'(cnt), 8);

    // R7: start mode
    do_reset();
    mode = 3'b110; tsel = 3'b110;
    tick(4);
    chk("R7 idle before trigger", int'(cnt), 0);
    tin_b = 1'b1;
    tick(1);
    chk("R7 not yet running", int'(run), 0);
    tick(1);
    chk("R7 started", int'(run), 1);
    tick(3);
    chk("R7 counting", int'(cnt), 3);
    tin_b = 1'b0;
    tick(4);
    chk("R7 keeps running after fall", int'(cnt), 7);
    chk("R7 run latched", int'(run), 1);
    mode = 3'b000;
    tick(3);
    chk("R7 stopped after leaving mode", int'(run), 0);
    chk("R7 value held", int'(cnt), 8);

    // R9 R10: prescaler and wrap sweep
    for (int p = 0; p < 4; p++) begin
      do_reset();
      psc = PSC_W'(p); mode = 3'b100; tsel = 3'b101; sw_run = 1'b1;
      arr_pre = 8'd3; cmp_pre = 8'd2;
      tick(2);
      tin_a = 1'b1;
      tick(2);
      chk("R10 initial load", int'(arr_act), 3);
      arr_pre = 8'd6; cmp_pre = 8'd5;
      for (int j = 1; j <= 48; j++) begin
        int t, ecnt, eupd, earr;
        tick(1);
        t = j / (p + 1);
        ecnt = (t < 4) ? t : (t - 4) % 7;
        eupd = ((j % (p + 1)) == 0 && t >= 4 && ((t - 4) % 7) == 0) ? 1 : 0;
        earr = (t < 4) ? 3 : 6;
        chk("R9 prescaled count", int'(cnt), ecnt);
        chk("R10 wrap update", int'(upd), eupd);
        chk("R10 active reload", int'(arr_act), earr);
        chk("R10 active compare", int'(cmp_act), (t < 4) ? 2 : 5);
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule